// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst in a synchronous burst memory. A burst begins when either of two active-low address strobes is sampled at a rising clock edge. At that edge the external start address is captured. After that, an active-low advance input steps the two low address bits through the burst order, one beat per edge. The upper bits stay as captured. When advance is inactive, the current address is held, which gives the access a wait state.

A static order input selects the beat order. With the input high, the order is interleaved: the low bits are the start bits XORed with the beat count. With the input low, the order is linear: the low bits count up from the start value and wrap modulo four. The processor strobe is qualified by the primary chip enable, which comes from outside the block. The controller strobe is not qualified. The memory array and the data path are not part of this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and burst_start_o is 0.
- R2: A rising edge with proc_strobe_ni low and ce_ni low loads addr_i. From the next cycle, addr_o equals the loaded address and burst_start_o is 1.
- R3: A rising edge with ctrl_strobe_ni low loads addr_i and sets burst_start_o, whatever the value of ce_ni.
- R4: With ce_ni high, proc_strobe_ni is ignored. The edge acts as an advance or a hold, as adv_ni decides, and burst_start_o goes to 0.
- R5: With order_i high (interleaved), beat k of a burst has addr_o[1:0] = start[1:0] XOR k. Beat 0 is the loaded address.
- R6: With order_i low (linear), beat k has addr_o[1:0] = (start[1:0] + k) mod 4.
- R7: At an edge with no load and adv_ni high, addr_o keeps its value (suspend).
- R8: addr_o[14:2] changes only at a load edge.
- R9: burst_start_o is 1 only in the cycle after a load edge.
- R10: Advancing past the fourth beat wraps the beat count back to 0, so the first beat address returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, qualified by ce_ni |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_i | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_i | input | 15 | External start address |
| addr_o | output | 15 | Current burst word address |
| burst_start_o | output | 1 | High in the first beat of a burst |

## Verification
On every cycle, the assertions check the following: the load result, the hold on suspend, that the upper bits stay put, that the start flag lasts a single cycle, that a gated processor strobe is rejected, and the plus-one step of linear order. The full interleaved sequence, the wrap after four beats, and the interaction of suspends with both orders can only be shown by the bench. It sweeps every start offset under both orders and both strobes, and compares each beat against an arithmetic model.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned BEAT_W = 2;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/bsq_strobe_dec.sv
module bsq_strobe_dec (
  input  logic proc_strobe_ni,
  input  logic ctrl_strobe_ni,
  input  logic ce_ni,
  output logic load_o
);
  // processor strobe gated by chip enable; controller strobe is not
  assign load_o = (!proc_strobe_ni && !ce_ni) || !ctrl_strobe_ni;
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  output logic [BEAT_W-1:0] beat_o,
  output logic              first_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o  <= '0;
      first_o <= 1'b0;
    end else if (load_i) begin
      beat_o  <= '0;
      first_o <= 1'b1;
    end else begin
      first_o <= 1'b0;
      if (!adv_ni) beat_o <= beat_o + 1'b1;  // wraps naturally
    end
  end
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int unsigned BEAT_W = 2
) (
  input  bsq_pkg::order_e   order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] ilv, lin;
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ beat_i[b];
  end
  assign lin   = start_i + beat_i;
  assign low_o = (order_i == bsq_pkg::ORD_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned ADDR_W = bsq_pkg::ADDR_W,
  parameter int unsigned BEAT_W = bsq_pkg::BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_start_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [BEAT_W-1:0] beat, low;
  logic [ADDR_W-1:0] base;
  bsq_pkg::order_e   order;

  assign order = bsq_pkg::order_e'(order_i);

  bsq_strobe_dec i_dec (
    .proc_strobe_ni(proc_strobe_ni), .ctrl_strobe_ni(ctrl_strobe_ni),
    .ce_ni(ce_ni), .load_o(load)
  );

  bsq_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .adv_ni(adv_ni),
    .beat_o(beat), .first_o(burst_start_o)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .addr_i(addr_i), .base_o(base)
  );

  bsq_order_map #(.BEAT_W(BEAT_W)) i_map (
    .order_i(order), .start_i(base[BEAT_W-1:0]), .beat_i(beat), .low_o(low)
  );

  assign addr_o = {base[ADDR_W-1 -: HI_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              proc_strobe_ni,
  input logic              ctrl_strobe_ni,
  input logic              ce_ni,
  input logic              adv_ni,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              burst_start_o
);
  logic ld;
  assign ld = (!proc_strobe_ni && !ce_ni) || !ctrl_strobe_ni;

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (addr_o == '0 && !burst_start_o);
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (addr_o == $past(addr_i) && burst_start_o));

  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_strobe_ni && ce_ni) |=> burst_start_o);

  p_ignore_proc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && ce_ni && ctrl_strobe_ni) |=> !burst_start_o);

  p_linear_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !adv_ni && !order_i) |=>
      (order_i || addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

  p_suspend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_ni) |=> ($stable(addr_o) || !$stable(order_i)));

  p_upper_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> !burst_start_o);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (.*);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_P = 10;
  localparam int AW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic proc_n = 1'b1, ctrl_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, ord = 1'b1;
  logic [AW-1:0] a_in = '0;
  logic [AW-1:0] a_out;
  logic          start;

  int vecs = 0, errs = 0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic          m_first = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .proc_strobe_ni(proc_n), .ctrl_strobe_ni(ctrl_n),
    .ce_ni(ce_n), .adv_ni(adv_n), .order_i(ord), .addr_i(a_in),
    .addr_o(a_out), .burst_start_o(start)
  );

  function automatic logic [AW-1:0] exp_addr();
    int lo;
    lo = ord ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] e;
    e = exp_addr();
    vecs++;
    if (a_out !== e || start !== m_first) begin
      errs++;
      $display("FAIL %s addr=%h start=%b expected addr=%h start=%b", tag, a_out, start, e, m_first);
    end
  endtask

  task automatic cyc(logic p, logic c, logic ce, logic adv, logic [AW-1:0] a, string tag);
    proc_n = p; ctrl_n = c; ce_n = ce; adv_n = adv; a_in = a;
    @(posedge clk); #1;
    if ((!p && !ce) || !c) begin
      m_base = a; m_beat = 0; m_first = 1'b1;
    end else begin
      m_first = 1'b0;
      if (!adv) m_beat = (m_beat + 1) % 4;
    end
    check(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 1);
    check("R1 reset");
    rst_n = 1'b1;
    for (int md = 0; md < 2; md++) begin
      for (int sb = 0; sb < 2; sb++) begin
        for (int st = 0; st < 4; st++) begin
          logic [AW-1:0] a;
          a = AW'(((13'h0A5 + 13'(37*(md*8+sb*4+st))) << 2) | st);
          ord = logic'(md);
          if (sb == 0) cyc(1'b0, 1'b1, 1'b0, 1'b0, a, "R2 proc load");
          else         cyc(1'b1, 1'b0, 1'b1, 1'b0, a, "R3 ctrl load ce high");
          for (int k = 0; k < 7; k++) begin
            if (k == 2 || k == 5) cyc(1'b1, 1'b1, 1'b0, 1'b1, ~a, "R7 suspend");
            cyc(1'b1, 1'b1, 1'b0, 1'b0, ~a,
                md ? "R5 interleave beat R8 R9 R10" : "R6 linear beat R8 R9 R10");
          end
          // gated processor strobe: advance then hold
          cyc(1'b0, 1'b1, 1'b1, 1'b0, ~a, "R4 ignored proc adv");
          cyc(1'b0, 1'b1, 1'b1, 1'b1, ~a, "R4 ignored proc hold");
        end
      end
    end
    // both strobes with chip enable high still loads
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 15'h2AB6, "R3 both strobes");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 15'h0, "R9 start drops");
    // back-to-back loads
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 15'h7FFF, "R2 back to back");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 15'h0001, "R3 back to back");
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 15'h1234, "R10 wrap");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule